// File: doc/BRIEF.md
# Dual-Phase Frame Transmit Serializer

This block turns parallel transmit words into a serial bit stream grouped into frames. A frame holds one phase or two. Each phase has its own word size, picked from six fixed sizes, and its own word count of 1 to 128 words. A one-cycle frame-sync pulse starts a frame. At that pulse the block captures the configuration inputs and keeps them until the frame ends. It then pulls words through a ready/valid input and sends each word most significant bit first. The serial output advances one bit on each cycle in which the bit-clock enable is high.

The control logic is a five-state machine. `ST_IDLE` waits for a frame sync and moves to `ST_FIRST`. `ST_FIRST` checks the captured word-length codes. An illegal code sends it to `ST_HALT`. Legal codes make it load the first word and move to `ST_SHIFT`. `ST_SHIFT` moves one bit per enable. At the end of a word it loads the next word in the same cycle and stays in `ST_SHIFT`, unless that word was the last one of the frame. In that case it moves to `ST_DONE`. `ST_DONE` lasts one cycle and returns to `ST_IDLE`. `ST_HALT` holds the output low until a new frame sync moves it to `ST_FIRST`.

Top module: `dphase_tx_serializer`

## Requirements
- R1: The word-length code selects 8, 12, 16, 20, 24 or 32 bits for the values 0, 1, 2, 3, 4 and 5. Each word sends the low N bits of `in_data`, from bit N-1 down to bit 0.
- R2: A phase's count field holds the word count minus one. The field is 7 bits, so a phase carries 1 to 128 words.
- R3: With `cfg_dual`=0 every word uses the phase-1 length and `phase_id` stays 0. The phase-2 fields have no effect, and this includes a reserved phase-2 code.
- R4: With `cfg_dual`=1 the frame sends (cnt1+1) words of the phase-1 length first. It then sends (cnt2+1) words of the phase-2 length. `phase_id` reads 0 during phase 1 and 1 during phase 2.
- R5: The configuration is captured on the clock edge that accepts `fsync`, and later changes to the configuration inputs have no effect on that frame. An `fsync` that arrives while a frame is running is ignored.
- R6: A reserved code (6 or 7) on an active phase raises `cfg_err` from the second cycle after `fsync`. While `cfg_err` is high, `ser_out` and `in_ready` stay 0 and no `frame_done` occurs. The next `fsync` clears `cfg_err`.
- R7: `frame_done` is high for exactly one cycle, the cycle after the enable that sent the final bit.
- R8: If `in_valid` is low when a word is loaded, the previous word is sent again and `underrun` is set. `underrun` stays high until the next accepted `fsync`.
- R9: `in_ready` is high in the cycle after an accepted `fsync`. It is also high in each enabled cycle that ends a word other than the last word of the frame. `word_req` pulses in the cycle after each load. The serial bit changes only on enabled cycles.
- R10: After reset `ser_out`, `in_ready`, `word_req`, `phase_id`, `frame_done`, `cfg_err` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dual | input | 1 | 0 = single-phase frames, 1 = dual-phase frames |
| cfg_len1 | input | 3 | Phase-1 word-length code |
| cfg_len2 | input | 3 | Phase-2 word-length code |
| cfg_cnt1 | input | 7 | Phase-1 word count minus one |
| cfg_cnt2 | input | 7 | Phase-2 word count minus one |
| fsync | input | 1 | Frame-sync start pulse |
| bit_en | input | 1 | Bit-clock enable |
| in_data | input | 32 | Parallel transmit word |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | A word is taken on this clock edge |
| ser_out | output | 1 | Serial data |
| word_req | output | 1 | Pulse: a new word slot has started |
| phase_id | output | 1 | Current phase (0 or 1) |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | Reserved word-length code seen |
| underrun | output | 1 | A word was repeated for lack of data |

## Verification
The assertions assume that `fsync` is a single-cycle pulse. They also assume that the registered configuration changes only when `fsync` is accepted, so the phase-2 indicator can only be set in dual mode. The stimulus keeps `fsync` to one cycle. It scrambles the configuration inputs right after each sync to exercise R5, and pulses `fsync` once in the middle of some frames. It holds `bit_en` low in the cycle after the sync, so every sampled bit falls inside `ST_SHIFT`.

// File: rtl/dpts_pkg.sv
package dpts_pkg;

    localparam int WORD_W = 32;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SHIFT,
        ST_DONE,
        ST_HALT
    } tx_state_e;

endpackage

// File: rtl/dpts_len_decode.sv
module dpts_len_decode #(
    parameter int CODE_W = 3,
    parameter int LEN_W  = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  bits,
    output logic              bad
);
    always_comb begin
        bad  = 1'b0;
        bits = LEN_W'(8);
        unique case (code)
            CODE_W'(0): bits = LEN_W'(8);
            CODE_W'(1): bits = LEN_W'(12);
            CODE_W'(2): bits = LEN_W'(16);
            CODE_W'(3): bits = LEN_W'(20);
            CODE_W'(4): bits = LEN_W'(24);
            CODE_W'(5): bits = LEN_W'(32);
            default:    bad  = 1'b1;
        endcase
    end
endmodule

// File: rtl/dpts_word_shifter.sv
module dpts_word_shifter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    input  logic [LEN_W-1:0]  len,
    input  logic              step,
    output logic              ser_bit,
    output logic              last_bit
);
    logic [DATA_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_m1;

    assign len_m1 = len - LEN_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            if (take) begin
                word_q <= din;
            end
            idx_q <= len_m1[IDX_W-1:0];
        end else if (step) begin
            idx_q <= idx_q - IDX_W'(1);
        end
    end

    assign ser_bit  = word_q[idx_q];
    assign last_bit = (idx_q == '0);

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(idx_q) && $stable(word_q));  // R9
endmodule

// File: rtl/dpts_slot_counter.sv
module dpts_slot_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic             dual,
    input  logic [CNT_W-1:0] lim1,
    input  logic [CNT_W-1:0] lim2,
    output logic             phase,
    output logic             last_in_phase,
    output logic             last_in_frame
);
    logic [CNT_W-1:0] idx_q;
    logic             phase_q;
    logic [CNT_W-1:0] lim_cur;

    assign lim_cur       = phase_q ? lim2 : lim1;
    assign last_in_phase = (idx_q == lim_cur);
    assign last_in_frame = last_in_phase && (phase_q || !dual);
    assign phase         = phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            phase_q <= 1'b0;
        end else if (clear) begin
            idx_q   <= '0;
            phase_q <= 1'b0;
        end else if (advance) begin
            if (last_in_phase) begin
                idx_q   <= '0;
                phase_q <= 1'b1;
            end else begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    AST_PHASE2_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q |-> dual);  // R3
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (idx_q <= lim_cur));  // R2
endmodule

// File: rtl/dphase_tx_serializer.sv
module dphase_tx_serializer
    import dpts_pkg::*;
#(
    parameter int DATA_W = dpts_pkg::WORD_W,
    parameter int CODE_W = dpts_pkg::CODE_W,
    parameter int CNT_W  = dpts_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dual,
    input  logic [CODE_W-1:0] cfg_len1,
    input  logic [CODE_W-1:0] cfg_len2,
    input  logic [CNT_W-1:0]  cfg_cnt1,
    input  logic [CNT_W-1:0]  cfg_cnt2,
    input  logic              fsync,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              ser_out,
    output logic              word_req,
    output logic              phase_id,
    output logic              frame_done,
    output logic              cfg_err,
    output logic              underrun
);
    localparam int LEN_W    = $clog2(DATA_W) + 1;
    localparam int N_PHASES = 2;

    tx_state_e st_q, st_d;

    logic              dual_q;
    logic [CODE_W-1:0] code_q [N_PHASES];
    logic [CNT_W-1:0]  cnt1_q, cnt2_q;
    logic [LEN_W-1:0]  len_w  [N_PHASES];
    logic              bad_w  [N_PHASES];
    logic              illegal;

    logic accept_sync, load, step, advance;
    logic ser_bit, last_bit;
    logic phase, last_in_phase, last_in_frame;
    logic [LEN_W-1:0] len_cur, load_len;
    logic underrun_q, word_req_q;

    // Configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dual_q    <= 1'b0;
            code_q[0] <= '0;
            code_q[1] <= '0;
            cnt1_q    <= '0;
            cnt2_q    <= '0;
        end else if (accept_sync) begin
            dual_q    <= cfg_dual;
            code_q[0] <= cfg_len1;
            code_q[1] <= cfg_len2;
            cnt1_q    <= cfg_cnt1;
            cnt2_q    <= cfg_cnt2;
        end
    end

    for (genvar p = 0; p < N_PHASES; p++) begin : g_dec
        dpts_len_decode #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_dec (
            .code (code_q[p]),
            .bits (len_w[p]),
            .bad  (bad_w[p])
        );
    end

    assign illegal = bad_w[0] || (dual_q && bad_w[1]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and datapath controls
    always_comb begin
        st_d        = st_q;
        accept_sync = 1'b0;
        load        = 1'b0;
        step        = 1'b0;
        advance     = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_HALT: begin
                if (fsync) begin
                    accept_sync = 1'b1;
                    st_d        = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (illegal) begin
                    st_d = ST_HALT;
                end else begin
                    load = 1'b1;
                    st_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (bit_en) begin
                    if (!last_bit) begin
                        step = 1'b1;
                    end else if (last_in_frame) begin
                        st_d = ST_DONE;
                    end else begin
                        load    = 1'b1;
                        advance = 1'b1;
                    end
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign len_cur  = phase ? len_w[1] : len_w[0];
    assign load_len = (st_q != ST_SHIFT) ? len_w[0] :
                      (last_in_phase ? len_w[1] : len_cur);

    dpts_slot_counter #(.CNT_W(CNT_W)) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (accept_sync),
        .advance       (advance),
        .dual          (dual_q),
        .lim1          (cnt1_q),
        .lim2          (cnt2_q),
        .phase         (phase),
        .last_in_phase (last_in_phase),
        .last_in_frame (last_in_frame)
    );

    dpts_word_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .take     (in_valid),
        .din      (in_data),
        .len      (load_len),
        .step     (step),
        .ser_bit  (ser_bit),
        .last_bit (last_bit)
    );

    // Flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            underrun_q <= 1'b0;
            word_req_q <= 1'b0;
        end else begin
            word_req_q <= load;
            if (accept_sync)           underrun_q <= 1'b0;
            else if (load && !in_valid) underrun_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        in_ready   = load;
        ser_out    = (st_q == ST_SHIFT) ? ser_bit : 1'b0;
        frame_done = (st_q == ST_DONE);
        cfg_err    = (st_q == ST_HALT);
        phase_id   = phase;
        word_req   = word_req_q;
        underrun   = underrun_q;
    end

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!ser_out && !in_ready && !frame_done));  // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);  // R7
    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underrun);  // R8
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && $past(st_q) == ST_SHIFT) |->
            ($stable(cnt1_q) && $stable(cnt2_q) && $stable(dual_q)));  // R5
    AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && !bit_en) |=> $stable(ser_out));  // R9
endmodule

// File: tb/test_dphase_tx_serializer.sv
module test_dphase_tx_serializer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dual = 1'b0;
    logic [2:0]  cfg_len1 = '0, cfg_len2 = '0;
    logic [6:0]  cfg_cnt1 = '0, cfg_cnt2 = '0;
    logic        fsync = 1'b0, bit_en = 1'b0, in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, ser_out, word_req, phase_id, frame_done, cfg_err, underrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] last_w = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dphase_tx_serializer i_dphase_tx_serializer (
        .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_len1(cfg_len1),
        .cfg_len2(cfg_len2), .cfg_cnt1(cfg_cnt1), .cfg_cnt2(cfg_cnt2),
        .fsync(fsync), .bit_en(bit_en), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .ser_out(ser_out), .word_req(word_req),
        .phase_id(phase_id), .frame_done(frame_done), .cfg_err(cfg_err),
        .underrun(underrun)
    );

    function automatic int len_of(int c);
        case (c)
            0: return 8;
            1: return 12;
            2: return 16;
            3: return 20;
            4: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(bit dual, int c1, int c2, int n1, int n2,
                             int en_pct, int val_pct, bit poke);
        bit exp_q[$], act_q[$], exp_ph[$], act_ph[$];
        int slot = 0, nreq = 0, iter = 0, total, bad_bits = 0, bad_ph = 0, len;
        bit exp_under = 0, prev_en = 0, ph;
        logic [31:0] w;
        @(negedge clk);
        cfg_dual = dual; cfg_len1 = 3'(c1); cfg_len2 = 3'(c2);
        cfg_cnt1 = 7'(n1); cfg_cnt2 = 7'(n2);
        fsync = 1'b1; bit_en = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        fsync = 1'b0;
        // scramble the configuration after the sync (R5)
        cfg_dual = 1'($urandom); cfg_len1 = 3'($urandom); cfg_len2 = 3'($urandom);
        cfg_cnt1 = 7'($urandom); cfg_cnt2 = 7'($urandom);
        total = (n1 + 1) * len_of(c1) + (dual ? (n2 + 1) * len_of(c2) : 0);
        forever begin
            if (iter > 0) @(negedge clk);
            bit_en   = (iter == 0) ? 1'b0 : ($urandom_range(99) < en_pct);
            in_valid = ($urandom_range(99) < val_pct);
            in_data  = $urandom;
            fsync    = poke && (iter == 7);
            #1;
            if (word_req) nreq++;
            if (frame_done) break;
            if (bit_en) begin
                act_q.push_back(ser_out);
                act_ph.push_back(phase_id);
            end
            if (in_ready) begin
                ph  = (slot > n1);
                len = ph ? len_of(c2) : len_of(c1);
                w   = in_valid ? in_data : last_w;
                if (!in_valid) exp_under = 1'b1;
                last_w = w;
                for (int b = len - 1; b >= 0; b--) begin
                    exp_q.push_back(w[b]);
                    exp_ph.push_back(ph);
                end
                slot++;
            end
            prev_en = bit_en;
            iter++;
        end
        fsync = 1'b0;
        check(act_q.size() == total, "R2", "bits per frame", act_q.size(), total);
        check(slot == n1 + 1 + (dual ? n2 + 1 : 0), "R4", "words per frame",
              slot, n1 + 1 + (dual ? n2 + 1 : 0));
        for (int i = 0; i < act_q.size() && i < exp_q.size(); i++) begin
            if (act_q[i] != exp_q[i]) bad_bits++;
            if (act_ph[i] != exp_ph[i]) bad_ph++;
        end
        check(bad_bits == 0, "R1", "serial bit mismatches", bad_bits, 0);
        check(bad_ph == 0, dual ? "R4" : "R3", "phase_id mismatches", bad_ph, 0);
        check(prev_en, "R7", "enable before frame_done", prev_en, 1);
        check(underrun == exp_under, "R8", "underrun flag", underrun, exp_under);
        check(nreq == slot, "R9", "word_req pulses", nreq, slot);
        check(cfg_err == 1'b0, "R6", "cfg_err in good frame", cfg_err, 0);
        @(negedge clk);
        #1;
        check(frame_done == 1'b0, "R7", "frame_done width", frame_done, 0);
    endtask

    task automatic run_bad(bit dual, int c1, int c2);
        int noise = 0;
        @(negedge clk);
        cfg_dual = dual; cfg_len1 = 3'(c1); cfg_len2 = 3'(c2);
        cfg_cnt1 = 7'd3; cfg_cnt2 = 7'd3;
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        #1;
        check(in_ready == 1'b0, "R6", "in_ready on bad code", in_ready, 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            bit_en = 1'($urandom); in_valid = 1'($urandom); in_data = $urandom;
            #1;
            if (!cfg_err || ser_out || in_ready || frame_done) noise++;
        end
        check(noise == 0, "R6", "halt cycles not quiet", noise, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        #1;
        check({ser_out, in_ready, word_req, phase_id, frame_done, cfg_err, underrun} == 7'b0,
              "R10", "outputs in reset", 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check({ser_out, in_ready, word_req, phase_id, frame_done, cfg_err, underrun} == 7'b0,
              "R10", "outputs after reset", 0, 0);
        // directed corners
        run_frame(1'b0, 2, 7, 2, 5, 100, 100, 1'b0);   // R3 reserved phase-2 code ignored
        run_frame(1'b1, 5, 1, 0, 0, 100, 100, 1'b0);   // R4 one word per phase
        run_frame(1'b0, 0, 0, 127, 0, 100, 100, 1'b0); // R2 128 words
        run_frame(1'b1, 3, 4, 2, 3, 60, 50, 1'b1);     // R8 underrun, R5 mid-frame sync
        run_bad(1'b1, 1, 6);                            // R6 reserved phase-2 code
        run_frame(1'b0, 1, 0, 1, 0, 80, 100, 1'b0);    // R6 recovery clears flag
        run_bad(1'b0, 7, 0);                            // R6 reserved phase-1 code
        // constrained random frames
        for (int f = 0; f < 24; f++) begin
            run_frame(1'($urandom), $urandom_range(5), $urandom_range(5),
                      $urandom_range(7), $urandom_range(7),
                      40 + $urandom_range(60), 80 + $urandom_range(20), 1'($urandom));
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule